// File: doc/BRIEF.md
# Two-Register ALU with Condition Flags

This block is the execute stage for the two-register ALU format of a compact 16-bit-instruction processor. Each cycle that `valid_i` is high it takes a 4-bit operation code, the first operand (the current destination register value), the second operand (the source register value) and the current flags. From these it computes a result, a destination write-enable and the next flag values. All outputs are registered, so they appear on the clock edge after the inputs are sampled.

The sixteen operations cover:
- bitwise logic;
- shifts and rotates by an amount held in a register;
- addition and subtraction that use the carry;
- negation, comparison and bit test;
- a truncated multiply.

Each operation has its own rule for which flags it updates and whether the destination is written. The flag vector is ordered {N, Z, C, V}, with N at bit 3 and V at bit 0.

Top module: `reg_alu_flags`

## Requirements
- R1: Operation codes 8 (test: a AND b), 10 (compare: a minus b) and 11 (compare-negative: a plus b) drive `wr_en_o` low. Every other code drives it high.
- R2: Codes 0 (a AND b), 1 (a XOR b), 12 (a OR b), 14 (a AND NOT b), 15 (NOT b) and 8 (test, a AND b) produce the stated value. They leave C (bit 1) and V (bit 0) equal to the incoming flags.
- R3: Shift and rotate codes 2, 3, 4 and 7 use only b[7:0] as the amount, and keep V unchanged. An amount of zero returns a unchanged and keeps C unchanged.
- R4: Code 2 (shift left) and code 3 (shift right logical), for amounts 1..31: C is the last bit shifted out. At amount 32: result 0, and C is a[0] for left or a[31] for right. Above 32: result 0 and C 0.
- R5: Code 4 (shift right arithmetic) sign-fills. For amounts of 32 or more, both the result and C equal a[31]. Code 7 (rotate right) rotates by the amount modulo 32 and, for any nonzero amount, sets C to result[31].
- R6: Code 5 returns a+b+C and code 11 returns a+b. Both set C to the 32-bit carry-out and V to bit 31 of ((a XOR r) AND (b XOR r)).
- R7: Code 6 returns a-b-(1-C). It sets C when b-C+1 (computed without wrap) is at most a. It sets V to bit 31 of ((a XOR r) AND (NOT b XOR r)).
- R8: Code 10 returns a-b, with C set when b is at most a (unsigned). Code 9 returns 0-b, with C set only when b is 0. Both set V by the formula of R7, with a taken as 0 for code 9.
- R9: Code 13 returns the low 32 bits of a*b and leaves C and V unchanged.
- R10: For every code, N equals result[31] and Z is set exactly when the 32-bit result is zero. This holds for codes 8, 10 and 11 too, whose result appears on `result_o` but is not written.
- R11: Outputs change one clock edge after a valid input. `valid_o` follows `valid_i` by one cycle, and `wr_en_o` is low whenever `valid_o` is low. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand (destination register value) |
| b_i | input | 32 | Second operand (source register value) |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| valid_o | output | 1 | Registered result valid |
| wr_en_o | output | 1 | Destination write-enable |
| result_o | output | 32 | Operation result |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
Within a single operation, the carry path and the zero-flag path can fire together. A shift by exactly 32, or an add whose sum wraps to zero, both produces a zero result (Z set) and supplies a new C from the shifter or the adder. A subtraction with equal operands similarly sets Z and C at once. The bench provokes these cases by sweeping every code over corner operands (0, 1, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF) and all 16 incoming flag combinations. Shift amounts 0, 1, 31, 32, 33 and 255 are swept with the upper bits of b both clear and set. Each case is compared against an arithmetic model that shifts one bit at a time and adds in 64 bits, so simultaneous Z and C updates are judged independently of each other.

// File: rtl/reg_alu_flags.sv
module reg_alu_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   flags_i,
  output logic         valid_o,
  output logic         wr_en_o,
  output logic [W-1:0] result_o,
  output logic [3:0]   flags_o
);

  localparam int SW = $clog2(W);

  localparam logic [3:0] OP_AND = 4'h0, OP_XOR = 4'h1, OP_SHL = 4'h2, OP_SHR = 4'h3,
                         OP_SRA = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_ROT = 4'h7,
                         OP_TST = 4'h8, OP_NEG = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
                         OP_OR  = 4'hC, OP_MUL = 4'hD, OP_BIC = 4'hE, OP_NOT = 4'hF;

  wire c_in = flags_i[1];
  wire v_in = flags_i[0];
  wire [7:0] amt = b_i[7:0];

  wire [W:0]          shl_x = {1'b0, a_i} << amt;
  wire [W:0]          shr_x = {a_i, 1'b0} >> amt;
  wire signed [W:0]   sra_x = $signed({a_i, 1'b0}) >>> amt;
  wire [SW-1:0]       rot_n = amt[SW-1:0];
  wire [2*W-1:0]      rot_x = {a_i, a_i} >> rot_n;
  wire [W-1:0]        rot_r = rot_x[W-1:0];
  wire [2*W-1:0]      prod  = a_i * b_i;

  logic [W-1:0] add_x, add_y;
  logic         add_ci;
  wire  [W:0]   sum   = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_ci};
  wire  [W-1:0] sum_r = sum[W-1:0];
  wire          sum_v = add_x[W-1] == add_y[W-1] && sum_r[W-1] != add_x[W-1];

  always_comb begin
    add_x  = a_i;
    add_y  = ~b_i;
    add_ci = 1'b1;
    case (op_i)
      OP_ADC: begin add_y = b_i; add_ci = c_in; end
      OP_CMN: begin add_y = b_i; add_ci = 1'b0; end
      OP_SBC: add_ci = c_in;
      OP_NEG: add_x = '0;
      default: ;
    endcase
  end

  logic [W-1:0] res;
  logic         c_nx, v_nx;

  always_comb begin
    res  = sum_r;
    c_nx = c_in;
    v_nx = v_in;
    case (op_i)
      OP_AND, OP_TST: res = a_i & b_i;
      OP_XOR:         res = a_i ^ b_i;
      OP_OR:          res = a_i | b_i;
      OP_BIC:         res = a_i & ~b_i;
      OP_NOT:         res = ~b_i;
      OP_MUL:         res = prod[W-1:0];
      OP_SHL: if (amt == 8'd0) res = a_i;
              else begin res = shl_x[W-1:0]; c_nx = shl_x[W]; end
      OP_SHR: if (amt == 8'd0) res = a_i;
              else begin res = shr_x[W:1]; c_nx = shr_x[0]; end
      OP_SRA: if (amt == 8'd0) res = a_i;
              else begin res = sra_x[W:1]; c_nx = sra_x[0]; end
      OP_ROT: if (amt == 8'd0) res = a_i;
              else begin res = rot_r; c_nx = rot_r[W-1]; end
      default: begin res = sum_r; c_nx = sum[W]; v_nx = sum_v; end
    endcase
  end

  wire wr_nx = !(op_i == OP_TST || op_i == OP_CMP || op_i == OP_CMN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      wr_en_o <= valid_i && wr_nx;
      if (valid_i) begin
        result_o <= res;
        flags_o  <= {res[W-1], res == '0, c_nx, v_nx};
      end
    end
  end

  AST_FLAG_ONLY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (op_i == OP_TST || op_i == OP_CMP || op_i == OP_CMN) |=> !wr_en_o); // R1
  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (op_i == OP_AND || op_i == OP_XOR || op_i == OP_OR || op_i == OP_BIC || op_i == OP_NOT)
    |=> flags_o[1:0] == $past(flags_i[1:0])); // R2
  AST_ZERO_SHIFT_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (op_i == OP_SHL || op_i == OP_SHR || op_i == OP_SRA || op_i == OP_ROT) && b_i[7:0] == 8'd0
    |=> result_o == $past(a_i) && flags_o[1:0] == $past(flags_i[1:0])); // R3
  AST_MUL_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == OP_MUL |=> flags_o[1:0] == $past(flags_i[1:0])); // R9
  AST_NZ_TRACK_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> flags_o[3] == result_o[W-1] && flags_o[2] == (result_o == '0)); // R10
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> !wr_en_o); // R11
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o); // R11

endmodule

// File: tb/tb_reg_alu_flags.sv
`timescale 1ns/1ps
module tb_reg_alu_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [3:0]  flags_i = '0;
  logic        valid_o, wr_en_o;
  logic [31:0] result_o;
  logic [3:0]  flags_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  reg_alu_flags #(.W(32)) dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flags_i(flags_i), .valid_o(valid_o), .wr_en_o(wr_en_o), .result_o(result_o), .flags_o(flags_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] op, input logic [7:0] amt);
    case (op)
      4'h0, 4'h1, 4'h8, 4'hC, 4'hE, 4'hF: return "R2";
      4'h2, 4'h3: return (amt == 0) ? "R3" : "R4";
      4'h4, 4'h7: return (amt == 0) ? "R3" : "R5";
      4'h5, 4'hB: return "R6";
      4'h6: return "R7";
      4'h9, 4'hA: return "R8";
      default: return "R9";
    endcase
  endfunction

  // returns {wr, N, Z, C, V, result}
  function automatic logic [36:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [3:0] f);
    logic [31:0] r = 32'h0;
    logic c = f[1];
    logic v = f[0];
    logic [63:0] w;
    int n = int'(b[7:0]);
    case (op)
      4'h0, 4'h8: r = a & b;
      4'h1: r = a ^ b;
      4'hC: r = a | b;
      4'hE: r = a & ~b;
      4'hF: r = ~b;
      4'hD: begin w = 64'(a) * 64'(b); r = w[31:0]; end
      4'h2: begin r = a; for (int i = 0; i < n; i++) begin c = r[31]; r = r << 1; end end
      4'h3: begin r = a; for (int i = 0; i < n; i++) begin c = r[0]; r = r >> 1; end end
      4'h4: begin r = a; for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end end
      4'h7: begin
        r = a;
        for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
        if (n != 0) c = r[31];
      end
      4'h5, 4'hB: begin
        w = 64'(a) + 64'(b) + ((op == 4'h5) ? 64'(f[1]) : 64'd0);
        r = w[31:0]; c = w[32]; v = ((a ^ r) & (b ^ r)) >> 31 != 0;
      end
      4'h6: begin
        r = a - b - 32'(!f[1]);
        c = (64'(b) - 64'(f[1]) + 64'd1) <= 64'(a);
        v = ((a ^ r) & (~b ^ r)) >> 31 != 0;
      end
      4'hA: begin r = a - b; c = b <= a; v = ((a ^ r) & (~b ^ r)) >> 31 != 0; end
      default: begin r = 32'h0 - b; c = b == 0; v = (r & (~b ^ r)) >> 31 != 0; end
    endcase
    return {!(op == 4'h8 || op == 4'hA || op == 4'hB), r[31], r == 0, c, v, r};
  endfunction

  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input logic [3:0] f);
    logic [36:0] e;
    @(negedge clk);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b; flags_i = f;
    e = model(op, a, b, f);
    @(posedge clk);
    #1;
    check({op_tag(op, b[7:0]), " result/CV"}, {32'h0, result_o, flags_o[1:0]}, {32'h0, e[31:0], e[33:32]});
    check("R1 write-enable", 64'(wr_en_o), 64'(e[36]));
    check("R10 N/Z", 64'(flags_o[3:2]), 64'(e[35:34]));
    check("R11 valid", 64'(valid_o), 64'd1);
  endtask

  logic [31:0] corner [5] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
  logic [7:0]  amts   [6] = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd255};

  initial begin
    #(4 * 200000);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #9;
    check("R11 reset outputs", {26'h0, valid_o, wr_en_o, result_o, flags_o}, 64'h0);
    rst_n = 1'b1;
    // corner operands, every code, every flag combination
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 5; ia++)
        for (int ib = 0; ib < 5; ib++)
          for (int f = 0; f < 16; f++)
            run(4'(op), corner[ia], corner[ib], 4'(f));
    // shift amounts, upper bits of b clear and set (R3 low byte only)
    for (int op = 0; op < 4; op++)
      for (int ia = 0; ia < 5; ia++)
        for (int k = 0; k < 6; k++)
          for (int hi = 0; hi < 2; hi++)
            for (int f = 0; f < 4; f++) begin
              logic [3:0] sop = (op == 0) ? 4'h2 : (op == 1) ? 4'h3 : (op == 2) ? 4'h4 : 4'h7;
              run(sop, corner[ia] ^ (ia == 0 ? 32'h0 : 32'h0123_4560),
                  {(hi != 0) ? 24'hFFFFFF : 24'h000000, amts[k]}, {f[0], 1'b0, f[1], 1'b1});
            end
    // random operands
    for (int i = 0; i < 3000; i++)
      run(4'($urandom_range(0, 15)), $urandom, (i % 3 == 0) ? 32'($urandom_range(0, 40)) : $urandom,
          4'($urandom_range(0, 15)));
    // idle: no write, valid low (R11)
    @(negedge clk);
    valid_i = 1'b0; op_i = 4'h0;
    @(posedge clk);
    #1;
    check("R11 idle valid", 64'(valid_o), 64'd0);
    check("R11 idle write-enable", 64'(wr_en_o), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule